// File: doc/BRIEF.md
# Serial Gain Word Control Interface

This block is the digital control front end of a programmable-gain line driver. A host writes an 8-bit gain word over three wires: a serial clock, an active-low load enable and a serial data line. All three lines are oversampled in a system clock domain. Each line passes through a two-flop synchronizer, and its edges are detected after that. While the load enable is low, bits shift into a shift register. The gain that is currently applied does not change during loading. When the load enable rises, the word is committed to a holding latch that drives the gain decoder.

A committed word outside the legal code span is clamped, and a flag records the clamp. A second flag records a word that was committed after a shift count other than eight. The transmit-enable and sleep inputs act asynchronously. They are decoded combinationally into three mutually exclusive controls: amplifier enable, power-down (high output impedance) and output mute (between-burst mode).

The system clock must run at least four times faster than the serial clock. Each serial level must be held for at least two system clock cycles.

Top module: `gainword_frontend`

## Requirements
- R1: The gain word is 8 bits wide and is shifted in most significant bit first. After eight shifts, the first bit received sits in bit 7 of the committed word.
- R2: A bit is captured only on a rising edge of the serial clock. A change of the data line while the serial clock is high, or on its falling edge, does not alter the word.
- R3: While the load enable is low, the applied gain code keeps its previous value.
- R4: A rising edge of the load enable commits the shift register to the gain latch. Serial clock edges seen while the enable is high are ignored, including an edge that lands in the same system cycle as the enable's rising edge.
- R5: After reset, the gain code is 1 (minimum gain), and the valid strobe and both error flags are low.
- R6: A committed word of 0 is applied as code 1, and a word above 60 is applied as code 60. In both cases the range flag goes high. A word from 1 to 60 is applied unchanged and clears the range flag.
- R7: The code-valid output pulses high for exactly one system cycle per commit. The new gain code appears on the third system clock edge, counting from the first edge that samples the load enable high.
- R8: When the number of rising serial clock edges since the enable fell is not exactly eight, the count flag is set at commit, and the latch takes the last eight bits shifted. A commit after exactly eight edges clears the flag.
- R9: The power controls follow the transmit-enable and sleep inputs without involving the clock. Sleep input low gives power-down high with amplifier enable and mute low. Sleep high with transmit enable low gives mute high only. Both high give amplifier enable high only.
- R10: The range and count flags keep their values until the next commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial clock; data is captured on its rising edge |
| ser_load_n_i | input | 1 | Active-low load enable; its rising edge commits the word |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| tx_en_i | input | 1 | Transmit enable; low mutes the output |
| sleep_n_i | input | 1 | Active-low sleep; low powers the amplifier down |
| gain_code_o | output | 8 | Latched gain code, 1 to 60 |
| code_valid_o | output | 1 | One-cycle strobe on each commit |
| range_err_o | output | 1 | Last committed word was clamped |
| count_err_o | output | 1 | Last commit followed a shift count other than eight |
| amp_en_o | output | 1 | Amplifier active (forward transmission) |
| power_down_o | output | 1 | Full power-down, high output impedance |
| mute_o | output | 1 | Between-burst mute |

## Verification
Two events can fall in the same system cycle: a rising edge of the serial clock and the rising edge of the load enable. The bench raises both pins at the same instant after a full eight-bit load. It expects the extra bit to be dropped, with the committed code equal to the eight earlier bits and the count flag low. A per-cycle reference model, built from queues of pin samples, tracks the shift register, shift count and latch on every clock. It compares the gain code, the flags and the strobe on every clock, so a one-cycle slip in either event is reported.

// File: rtl/gw_pkg.sv
package gw_pkg;

    localparam int WORD_W = 8;
    localparam int CNT_W  = 4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic sclk;
        logic load_n;
        logic sdat;
    } ser_t;

    localparam ser_t SER_IDLE = '{sclk: 1'b0, load_n: 1'b1, sdat: 1'b0};

    typedef struct packed {
        logic  strobe;
        word_t word;
        logic  count_bad;
    } commit_t;

    typedef enum logic [1:0] {
        PM_ACTIVE = 2'd0,
        PM_MUTED  = 2'd1,
        PM_OFF    = 2'd2
    } pwr_mode_t;

    function automatic word_t clamp_code(input word_t raw, input word_t lo, input word_t hi);
        if (raw < lo) return lo;
        if (raw > hi) return hi;
        return raw;
    endfunction

    function automatic logic outside_span(input word_t raw, input word_t lo, input word_t hi);
        return (raw < lo) || (raw > hi);
    endfunction

endpackage

// File: rtl/gw_sync.sv
module gw_sync #(
    parameter int          STAGES  = 2,
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [W-1:0] q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q <= RST_VAL;
                else     q <= g_stage[s-1].q;
            end
        end
    end

    assign q_o = g_stage[STAGES-1].q;

endmodule

// File: rtl/gw_shifter.sv
module gw_shifter
    import gw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ser_t    pins_i,
    output commit_t commit_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    logic             sclk_prev_q;
    logic             load_prev_q;
    word_t            sr_q;
    logic [CNT_W-1:0] cnt_q;

    logic sclk_rise, load_rise, load_fall, shift_w;

    always_comb begin
        sclk_rise = pins_i.sclk & ~sclk_prev_q;
        load_rise = pins_i.load_n & ~load_prev_q;
        load_fall = ~pins_i.load_n & load_prev_q;
        shift_w   = sclk_rise & ~pins_i.load_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev_q <= SER_IDLE.sclk;
            load_prev_q <= SER_IDLE.load_n;
            sr_q        <= '0;
            cnt_q       <= '0;
        end else begin
            sclk_prev_q <= pins_i.sclk;
            load_prev_q <= pins_i.load_n;
            if (shift_w) sr_q <= {sr_q[WORD_W-2:0], pins_i.sdat};
            if (load_fall)
                cnt_q <= shift_w ? CNT_W'(1) : '0;
            else if (shift_w && cnt_q != '1)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        commit_o.strobe    = load_rise;
        commit_o.word      = sr_q;
        commit_o.count_bad = (cnt_q != FULL_CNT);
    end

    // R4: no shifting while the synchronized enable is high
    assert_load_inhibit_R4: assert property (@(posedge clk) disable iff (rst)
        pins_i.load_n |=> $stable(sr_q));

    // R1, R2: each shift brings the sampled bit in at the low end
    assert_shift_capture_R1: assert property (@(posedge clk) disable iff (rst)
        shift_w |=> (sr_q[0] == $past(pins_i.sdat)));

endmodule

// File: rtl/gw_latch.sv
module gw_latch
    import gw_pkg::*;
#(
    parameter word_t CODE_MIN   = 8'd1,
    parameter word_t CODE_MAX   = 8'd60,
    parameter word_t CODE_RESET = 8'd1
) (
    input  logic    clk,
    input  logic    rst,
    input  commit_t commit_i,
    output word_t   gain_o,
    output logic    valid_o,
    output logic    range_err_o,
    output logic    count_err_o
);

    word_t gain_q;
    logic  valid_q, range_q, count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gain_q  <= CODE_RESET;
            valid_q <= 1'b0;
            range_q <= 1'b0;
            count_q <= 1'b0;
        end else begin
            valid_q <= commit_i.strobe;
            if (commit_i.strobe) begin
                gain_q  <= clamp_code(commit_i.word, CODE_MIN, CODE_MAX);
                range_q <= outside_span(commit_i.word, CODE_MIN, CODE_MAX);
                count_q <= commit_i.count_bad;
            end
        end
    end

    assign gain_o      = gain_q;
    assign valid_o     = valid_q;
    assign range_err_o = range_q;
    assign count_err_o = count_q;

    // R6: the applied code never leaves the legal span
    assert_code_span_R6: assert property (@(posedge clk) disable iff (rst)
        (gain_q >= CODE_MIN) && (gain_q <= CODE_MAX));

    // R3: without a commit the applied code holds
    assert_hold_gain_R3: assert property (@(posedge clk) disable iff (rst)
        !commit_i.strobe |=> $stable(gain_q));

    // R7: the valid strobe lasts one cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    // R8: count flag reflects the shift count at commit
    assert_count_flag_R8: assert property (@(posedge clk) disable iff (rst)
        commit_i.strobe |=> (count_q == $past(commit_i.count_bad)));

    // R10: flags hold between commits
    assert_flags_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !commit_i.strobe |=> ($stable(range_q) && $stable(count_q)));

endmodule

// File: rtl/gw_power.sv
module gw_power
    import gw_pkg::*;
(
    input  logic tx_en_i,
    input  logic sleep_n_i,
    output logic amp_en_o,
    output logic power_down_o,
    output logic mute_o
);

    pwr_mode_t mode;

    always_comb begin
        if (!sleep_n_i)    mode = PM_OFF;
        else if (!tx_en_i) mode = PM_MUTED;
        else               mode = PM_ACTIVE;
    end

    always_comb begin
        amp_en_o     = 1'b0;
        power_down_o = 1'b0;
        mute_o       = 1'b0;
        case (mode)
            PM_ACTIVE: amp_en_o     = 1'b1;
            PM_MUTED:  mute_o       = 1'b1;
            default:   power_down_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/gainword_frontend.sv
module gainword_frontend
    import gw_pkg::*;
#(
    parameter int    SYNC_STAGES = 2,
    parameter word_t CODE_MIN    = 8'd1,
    parameter word_t CODE_MAX    = 8'd60,
    parameter word_t CODE_RESET  = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_load_n_i,
    input  logic              ser_dat_i,
    input  logic              tx_en_i,
    input  logic              sleep_n_i,
    output logic [WORD_W-1:0] gain_code_o,
    output logic              code_valid_o,
    output logic              range_err_o,
    output logic              count_err_o,
    output logic              amp_en_o,
    output logic              power_down_o,
    output logic              mute_o
);

    localparam int SER_W = $bits(ser_t);

    ser_t    pins_raw, pins_s;
    commit_t commit;

    assign pins_raw = '{sclk: ser_clk_i, load_n: ser_load_n_i, sdat: ser_dat_i};

    gw_sync #(
        .STAGES  (SYNC_STAGES),
        .W       (SER_W),
        .RST_VAL (SER_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (pins_raw),
        .q_o (pins_s)
    );

    gw_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .pins_i   (pins_s),
        .commit_o (commit)
    );

    gw_latch #(
        .CODE_MIN   (CODE_MIN),
        .CODE_MAX   (CODE_MAX),
        .CODE_RESET (CODE_RESET)
    ) u_latch (
        .clk         (clk),
        .rst         (rst),
        .commit_i    (commit),
        .gain_o      (gain_code_o),
        .valid_o     (code_valid_o),
        .range_err_o (range_err_o),
        .count_err_o (count_err_o)
    );

    gw_power u_pwr (
        .tx_en_i      (tx_en_i),
        .sleep_n_i    (sleep_n_i),
        .amp_en_o     (amp_en_o),
        .power_down_o (power_down_o),
        .mute_o       (mute_o)
    );

    // R5: reset leaves the minimum code applied
    assert_reset_code_R5: assert property (@(posedge clk)
        $past(rst) |-> (gain_code_o == CODE_RESET && !code_valid_o));

endmodule

// File: tb/tb_gainword_frontend.sv
module tb_gainword_frontend;
    import gw_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic sclk = 1'b0, lden_n = 1'b1, sdat = 1'b0, txen = 1'b0, slp_n = 1'b1;
    logic [7:0] gain_code;
    logic code_valid, range_err, count_err, amp_en, power_down, mute;

    gainword_frontend dut (
        .clk(clk), .rst(rst),
        .ser_clk_i(sclk), .ser_load_n_i(lden_n), .ser_dat_i(sdat),
        .tx_en_i(txen), .sleep_n_i(slp_n),
        .gain_code_o(gain_code), .code_valid_o(code_valid),
        .range_err_o(range_err), .count_err_o(count_err),
        .amp_en_o(amp_en), .power_down_o(power_down), .mute_o(mute)
    );

    int checks = 0, errors = 0;
    int pulses = 0, m_commits = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model: pin samples per edge as {clk, enable, data}
    logic [2:0] hq[$] = '{3'b010, 3'b010, 3'b010, 3'b010};
    logic [7:0] m_sr = '0;
    int m_cnt = 0, m_gain = 1;
    bit m_rng = 0, m_cerr = 0, m_valid = 0;

    always @(posedge clk) begin
        logic [2:0] s2, pv;
        bit rc, sh, fe, re;
        if (rst) begin
            m_sr = '0; m_cnt = 0; m_gain = 1; m_rng = 0; m_cerr = 0; m_valid = 0;
            hq.push_front(3'b010);
        end else begin
            s2 = hq[1];
            pv = hq[2];
            rc = s2[2] && !pv[2];
            sh = rc && !s2[1];
            fe = !s2[1] && pv[1];
            re = s2[1] && !pv[1];
            m_valid = 0;
            if (re) begin
                m_valid = 1;
                m_commits++;
                m_rng  = (m_sr == 0) || (m_sr > 60);
                m_gain = (m_sr == 0) ? 1 : (m_sr > 60) ? 60 : int'(m_sr);
                m_cerr = (m_cnt != 8);
            end
            if (fe) m_cnt = sh ? 1 : 0;
            else if (sh && m_cnt < 15) m_cnt++;
            if (sh) m_sr = {m_sr[6:0], s2[0]};
            hq.push_front({sclk, lden_n, sdat});
        end
        while (hq.size() > 6) void'(hq.pop_back());
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(gain_code == m_gain, "R6 gain code vs model", gain_code, m_gain);
            chk(range_err == m_rng, "R10 range flag vs model", range_err, m_rng);
            chk(count_err == m_cerr, "R8 count flag vs model", count_err, m_cerr);
            chk(code_valid == m_valid, "R7 valid strobe vs model", code_valid, m_valid);
            if (code_valid) pulses++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_word(input logic [15:0] bits, input int n, input bit coincide);
        lden_n = 1'b0;
        tick(4);
        for (int i = n - 1; i >= 0; i--) begin
            sdat = bits[i];
            tick(2);
            sclk = 1'b1;
            tick(2);
            sdat = ~bits[i];   // R2: change while clock high must not matter
            tick(2);
            sclk = 1'b0;
            tick(2);
        end
        if (coincide) begin
            sdat = 1'b1;
            tick(2);
            sclk   = 1'b1;
            lden_n = 1'b1;
            tick(4);
            sclk = 1'b0;
        end else begin
            lden_n = 1'b1;
        end
        tick(10);
    endtask

    task automatic expect_state(input int g, input bit r, input bit c, input string tag);
        chk(gain_code == g, {tag, " gain"}, gain_code, g);
        chk(range_err == r, {tag, " range flag"}, range_err, r);
        chk(count_err == c, {tag, " count flag"}, count_err, c);
    endtask

    task automatic expect_power(input bit a, input bit p, input bit m, input string tag);
        #1;
        chk(amp_en == a, {tag, " amp enable"}, amp_en, a);
        chk(power_down == p, {tag, " power down"}, power_down, p);
        chk(mute == m, {tag, " mute"}, mute, m);
    endtask

    initial begin : watchdog
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        tick(4);
        expect_state(1, 0, 0, "R5 reset");
        chk(code_valid == 0, "R5 reset strobe", code_valid, 0);
        rst = 1'b0;
        tick(4);

        load_word(16'h001E, 8, 0); expect_state(30, 0, 0, "R1 msb-first word");
        load_word(16'h0000, 8, 0); expect_state(1, 1, 0, "R6 zero clamps");
        load_word(16'h00C8, 8, 0); expect_state(60, 1, 0, "R6 high clamps");
        load_word(16'h003C, 8, 0); expect_state(60, 0, 0, "R6 top code");
        load_word(16'h0001, 8, 0); expect_state(1, 0, 0, "R6 bottom code");
        load_word(16'h0021, 8, 0); expect_state(33, 0, 0, "R2 data flips");
        load_word(16'h0003, 5, 0); expect_state(35, 0, 1, "R8 short load");
        load_word(16'h022D, 10, 0); expect_state(45, 0, 1, "R8 long load");

        // serial clocks while enable high are ignored, then an empty load
        for (int k = 0; k < 3; k++) begin
            sdat = 1'b1; sclk = 1'b1; tick(3); sclk = 1'b0; tick(3);
        end
        load_word(16'h0000, 0, 0); expect_state(45, 0, 1, "R4 inhibited shifts");
        tick(20); expect_state(45, 0, 1, "R10 flags hold");

        load_word(16'h000A, 8, 1); expect_state(10, 0, 0, "R4 coincident edge");
        load_word(16'h003D, 8, 0); expect_state(60, 1, 0, "R6 code 61");

        // R3: gain holds in the middle of a load
        lden_n = 1'b0; tick(4);
        for (int i = 7; i >= 0; i--) begin
            sdat = 8'h32 >> i; tick(2); sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
            if (i == 4) expect_state(60, 1, 0, "R3 mid-load hold");
        end
        lden_n = 1'b1; tick(2);
        chk(gain_code == 60, "R7 not yet applied", gain_code, 60);
        tick(10);
        expect_state(50, 0, 0, "R3 commit after hold");

        chk(pulses == 12, "R7 strobe count", pulses, 12);
        chk(m_commits == 12, "R7 commit count", m_commits, 12);

        slp_n = 1'b0; txen = 1'b0; expect_power(0, 1, 0, "R9 sleep tx off");
        slp_n = 1'b0; txen = 1'b1; expect_power(0, 1, 0, "R9 sleep tx on");
        slp_n = 1'b1; txen = 1'b0; expect_power(0, 0, 1, "R9 awake muted");
        slp_n = 1'b1; txen = 1'b1; expect_power(1, 0, 0, "R9 awake active");
        tick(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule